// File: doc/BRIEF.md
# Windowed Command and Interrupt Status Unit

This block sits at the single shared command/status offset of a network adapter whose registers are reached through banks, or windows. A 16-bit host write to the offset is a command: the opcode is in bits 15:11 and an 11-bit argument is in bits 10:0. A host read of the same offset returns interrupt status, with the current window number in the top three bits. The block holds the window selector, an interrupt-enable mask, a separate indication mask that decides which status bits the host can see, the interrupt sources and the interrupt latch. It drives the interrupt line.

The data path, FIFOs and media logic are not part of this block. Their events reach it as one-cycle pulses on `src_event`. Reset commands have a latency, and the block models it as a busy flag that stays set for a fixed number of cycles. While that flag is set, the block ignores further commands.

Top module: `wcmd_status_unit`

## Requirements
- R1: After reset, `status` reads 0x0000, `irq` is low, the window is 0, both masks are 0 and no command is in progress.
- R2: An accepted write with opcode 0x01 (opcode = `cmd_data[15:11]`) loads the window from argument bits 2:0. Argument bits 10:3 are ignored. `status[15:13]` shows the window. The window changes on no other command except the opcode 0x00 global reset.
- R3: A pulse on `src_event[k]` sets source bit k+1 of the status (bits 1..8). A source bit stays set until it is acknowledged or wiped.
- R4: Opcode 0x0D clears every status bit 0..8 that is set in argument bits 8:0. Bit 0 is the interrupt latch. If an event pulse arrives in the same cycle as the clear, the event wins.
- R5: Opcode 0x0F loads the indication mask from argument bits 8:0. Status bits 8:0 read as (source bits and latch) AND this mask. A masked source is still recorded and appears once the mask opens.
- R6: Opcode 0x0E loads the interrupt-enable mask from argument bits 8:1. The latch sets in the cycle after a pulse arrives on a source that was enabled before that clock edge. `irq` = latch AND (any source bit that is set and enabled).
- R7: Opcode 0x0C sets source bit 6, the interrupt-requested bit. It has the same effect as an event on that bit.
- R8: Opcodes 0x00, 0x05 and 0x0B start a command in progress. Status bit 12 reads 1 for exactly BUSY_CYCLES cycles after the write.
- R9: Any command written while status bit 12 is 1 is ignored.
- R10: Global reset (0x00) also clears the sources, the latch, both masks and the window. Rx reset (0x05) and tx reset (0x0B) leave all of these unchanged.
- R11: Status bits 11:9 always read 0. Opcodes other than 0x00, 0x01, 0x05, 0x0B, 0x0C, 0x0D, 0x0E and 0x0F have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Host write strobe for the command offset |
| cmd_data | input | 16 | Command word: opcode in 15:11, argument in 10:0 |
| src_event | input | 8 | Event pulses from the data path; bit k sets status bit k+1 |
| status | output | 16 | Status read-back: window, busy, masked sources, latch |
| irq | output | 1 | Interrupt request line |

## Verification
The assertions check on every cycle that the window moves only after an accepted select or global reset, and that a command written while busy leaves the window unchanged. They also check that a busy period starts only from a reset opcode and never lasts more than BUSY_CYCLES cycles, and that the interrupt line is never high while the latch is clear. Several behaviours can only be shown by the bench scenarios: how acknowledge and events interact in the same cycle, a masked source appearing once the indication mask opens, the exact busy length, and the interrupt line following the enable mask.

// File: rtl/wcsu_pkg.sv
package wcsu_pkg;

    localparam int CMD_W  = 16;
    localparam int OP_W   = 5;
    localparam int WIN_W  = 3;
    localparam int SRC_N  = 8;
    localparam int MASK_W = SRC_N + 1;          // latch plus sources
    localparam int RSV_W  = CMD_W - WIN_W - 1 - MASK_W;
    localparam int REQ_BIT = 6;                 // status bit set by request command

    typedef enum logic [OP_W-1:0] {
        OP_GLOBAL_RST = 5'h00,
        OP_SEL_WIN    = 5'h01,
        OP_RX_RST     = 5'h05,
        OP_TX_RST     = 5'h0B,
        OP_REQ_IRQ    = 5'h0C,
        OP_ACK        = 5'h0D,
        OP_SET_IEN    = 5'h0E,
        OP_SET_IND    = 5'h0F
    } opcode_e;

    typedef struct packed {
        logic              sel_win;
        logic              ack;
        logic              set_ien;
        logic              set_ind;
        logic              req_irq;
        logic              wipe;
        logic              start_busy;
        logic [WIN_W-1:0]  win;
        logic [MASK_W-1:0] bits;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] w, input logic accept);
        cmd_t c;
        c      = '0;
        c.win  = w[WIN_W-1:0];
        c.bits = w[MASK_W-1:0];
        if (accept) begin
            case (opcode_e'(w[CMD_W-1 -: OP_W]))
                OP_GLOBAL_RST: begin c.wipe = 1'b1; c.start_busy = 1'b1; end
                OP_SEL_WIN:    c.sel_win = 1'b1;
                OP_RX_RST:     c.start_busy = 1'b1;
                OP_TX_RST:     c.start_busy = 1'b1;
                OP_REQ_IRQ:    c.req_irq = 1'b1;
                OP_ACK:        c.ack = 1'b1;
                OP_SET_IEN:    c.set_ien = 1'b1;
                OP_SET_IND:    c.set_ind = 1'b1;
                default:       ;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/wcsu_cmd_decode.sv
module wcsu_cmd_decode
    import wcsu_pkg::*;
(
    input  logic             wr_en,
    input  logic             busy,
    input  logic [CMD_W-1:0] wr_data,
    output cmd_t             cmd
);
    // commands arriving while busy are dropped here (R9)
    assign cmd = decode_cmd(wr_data, wr_en && !busy);
endmodule

// File: rtl/wcsu_busy_timer.sv
module wcsu_busy_timer #(
    parameter int BUSY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(BUSY_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/wcsu_irq_status.sv
module wcsu_irq_status
    import wcsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [SRC_N-1:0]  ev,
    output logic [MASK_W-1:0] visible,
    output logic              latch,
    output logic              irq
);
    logic [SRC_N-1:0]  src_q, ien_q, pulses, clr;
    logic [MASK_W-1:0] ind_q;
    logic              latch_q, hit, latch_clr;

    always_comb begin
        pulses = ev;
        if (cmd.req_irq)
            pulses[REQ_BIT-1] = 1'b1;
        if (cmd.wipe)
            clr = '1;
        else if (cmd.ack)
            clr = cmd.bits[MASK_W-1:1];
        else
            clr = '0;
        latch_clr = cmd.wipe || (cmd.ack && cmd.bits[0]);
        hit       = |(pulses & ien_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= '0;
            ien_q   <= '0;
            ind_q   <= '0;
            latch_q <= 1'b0;
        end else begin
            src_q   <= (src_q & ~clr) | pulses;
            latch_q <= (latch_q && !latch_clr) || hit;
            if (cmd.wipe)
                ien_q <= '0;
            else if (cmd.set_ien)
                ien_q <= cmd.bits[MASK_W-1:1];
            if (cmd.wipe)
                ind_q <= '0;
            else if (cmd.set_ind)
                ind_q <= cmd.bits;
        end
    end

    assign visible = {src_q, latch_q} & ind_q;
    assign latch   = latch_q;
    assign irq     = latch_q && |(src_q & ien_q);
endmodule

// File: rtl/wcmd_status_unit.sv
module wcmd_status_unit
    import wcsu_pkg::*;
#(
    parameter int BUSY_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic [SRC_N-1:0] src_event,
    output logic [CMD_W-1:0] status,
    output logic             irq
);
    cmd_t              cmd;
    logic              busy;
    logic              latch_w;
    logic [MASK_W-1:0] visible;
    logic [WIN_W-1:0]  win_q;

    wcsu_cmd_decode u_dec (
        .wr_en   (cmd_wr),
        .busy    (busy),
        .wr_data (cmd_data),
        .cmd     (cmd)
    );

    wcsu_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst   (rst),
        .start (cmd.start_busy),
        .busy  (busy)
    );

    wcsu_irq_status u_irq (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .ev      (src_event),
        .visible (visible),
        .latch   (latch_w),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst || cmd.wipe)
            win_q <= '0;
        else if (cmd.sel_win)
            win_q <= cmd.win;
    end

    assign status = {win_q, busy, {RSV_W{1'b0}}, visible};
endmodule

// File: rtl/wcsu_checker.sv
module wcsu_checker
    import wcsu_pkg::*;
#(
    parameter int BUSY_CYCLES = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_wr,
    input logic [CMD_W-1:0] cmd_data,
    input logic [CMD_W-1:0] status,
    input logic             irq,
    input logic             latch
);
    logic             busy;
    logic [OP_W-1:0]  op;
    logic [WIN_W-1:0] win;
    logic [31:0]      run_q;

    assign busy = status[CMD_W-WIN_W-1];
    assign op   = cmd_data[CMD_W-1 -: OP_W];
    assign win  = status[CMD_W-1 -: WIN_W];

    always_ff @(posedge clk) begin
        if (rst || !busy)
            run_q <= '0;
        else
            run_q <= run_q + 1;
    end

    a_r2_window_moves_on_select: assert property (@(posedge clk) disable iff (rst)
        (win != $past(win)) |-> $past(cmd_wr && !busy &&
            (op == OP_SEL_WIN || op == OP_GLOBAL_RST)));

    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy) |=> $stable(win));

    a_r8_busy_from_reset_op: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_wr && (op == OP_GLOBAL_RST ||
            op == OP_RX_RST || op == OP_TX_RST)));

    a_r8_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < BUSY_CYCLES));

    a_r6_irq_needs_latch: assert property (@(posedge clk) disable iff (rst)
        irq |-> latch);
endmodule

bind wcmd_status_unit wcsu_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_check (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr),
    .cmd_data (cmd_data),
    .status   (status),
    .irq      (irq),
    .latch    (latch_w)
);

// File: tb/tb_wcmd_status_unit.sv
`timescale 1ns/1ps
module tb_wcmd_status_unit;
    localparam int NBUSY = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_data = '0;
    logic [7:0]  src_event = '0;
    logic [15:0] status;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench reference state
    logic [2:0] m_win = '0;
    int         m_cnt = 0;
    logic [7:0] m_src = '0, m_ien = '0;
    logic [8:0] m_ind = '0;
    logic       m_lat = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    wcmd_status_unit #(.BUSY_CYCLES(NBUSY)) dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .src_event(src_event), .status(status), .irq(irq)
    );

    function automatic logic [15:0] exp_status();
        return {m_win, (m_cnt != 0), 3'b000, ({m_src, m_lat} & m_ind)};
    endfunction

    function automatic logic exp_irq();
        return m_lat && |(m_src & m_ien);
    endfunction

    function automatic logic [15:0] mk(input logic [4:0] op, input logic [10:0] arg);
        return {op, arg};
    endfunction

    task automatic model(input logic w, input logic [15:0] d, input logic [7:0] e);
        logic [7:0] pul, clr;
        logic       acc, hit, lclr;
        logic [4:0] op;
        op  = d[15:11];
        acc = w && (m_cnt == 0);
        pul = e;
        clr = '0;
        lclr = 1'b0;
        if (acc && op == 5'h0C) pul[5] = 1'b1;
        hit = |(pul & m_ien);
        if (m_cnt != 0) m_cnt--;
        if (acc) begin
            case (op)
                5'h00: begin clr = '1; lclr = 1'b1; m_ien = '0; m_ind = '0; m_win = '0; m_cnt = NBUSY; end
                5'h01: m_win = d[2:0];
                5'h05, 5'h0B: m_cnt = NBUSY;
                5'h0D: begin clr = d[8:1]; lclr = d[0]; end
                5'h0E: m_ien = d[8:1];
                5'h0F: m_ind = d[8:0];
                default: ;
            endcase
        end
        m_src = (m_src & ~clr) | pul;
        m_lat = (m_lat && !lclr) || hit;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // drive at negedge, clock, update model, compare at next negedge
    task automatic step(input string tag, input logic w, input logic [15:0] d, input logic [7:0] e);
        cmd_wr = w; cmd_data = d; src_event = e;
        @(posedge clk);
        model(w, d, e);
        @(negedge clk);
        cmd_wr = 1'b0; src_event = '0;
        chk({tag, " status"}, status, exp_status());
        chk({tag, " irq"}, {15'd0, irq}, {15'd0, exp_irq()});
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 16'h0, 8'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", status, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0);

        // R2 window select, upper argument bits ignored
        step("R2", 1'b1, mk(5'h01, 11'h7FD), 8'h0);
        chk("R2 window", {13'd0, status[15:13]}, 16'd5);

        // R3 and R5: event recorded while hidden, appears when mask opens
        step("R3", 1'b0, 16'h0, 8'h08);
        chk("R5 hidden", {7'd0, status[8:0]}, 16'h0);
        step("R5", 1'b1, mk(5'h0F, 11'h1FF), 8'h0);
        chk("R3 rx complete bit4", {7'd0, status[8:0]}, 16'h0010);

        // R6 enable rx complete then pulse it
        step("R6", 1'b1, mk(5'h0E, 11'h010), 8'h0);
        chk("R6 no irq before pulse", {15'd0, irq}, 16'h0);
        step("R6", 1'b0, 16'h0, 8'h08);
        chk("R6 irq raised", {15'd0, irq}, 16'h1);
        chk("R6 latch visible", {15'd0, status[0]}, 16'h1);

        // R4 ack source only: irq falls, latch stays
        step("R4", 1'b1, mk(5'h0D, 11'h010), 8'h0);
        chk("R4 irq after ack source", {15'd0, irq}, 16'h0);
        chk("R4 latch kept", {15'd0, status[0]}, 16'h1);
        step("R4", 1'b1, mk(5'h0D, 11'h001), 8'h0);
        chk("R4 latch cleared", {15'd0, status[0]}, 16'h0);
        // R4 event wins over simultaneous ack
        step("R4", 1'b1, mk(5'h0D, 11'h004), 8'h02);
        chk("R4 event wins", {15'd0, status[2]}, 16'h1);

        // R7 request interrupt sets bit 6
        step("R7", 1'b1, mk(5'h0C, 11'h0), 8'h0);
        chk("R7 bit6", {15'd0, status[6]}, 16'h1);

        // R11 unknown opcode has no effect, reserved bits zero
        step("R11", 1'b1, mk(5'h1F, 11'h7FF), 8'h0);
        chk("R11 reserved", {13'd0, status[11:9]}, 16'h0);

        // R8 tx reset busy exactly NBUSY cycles; R9 writes ignored; R10 state kept
        step("R8", 1'b1, mk(5'h0B, 11'h0), 8'h0);
        chk("R8 busy first", {15'd0, status[12]}, 16'h1);
        chk("R10 tx reset keeps window", {13'd0, status[15:13]}, 16'd5);
        step("R9", 1'b1, mk(5'h01, 11'h002), 8'h0);
        chk("R9 window unchanged", {13'd0, status[15:13]}, 16'd5);
        idle("R8", NBUSY - 2);
        chk("R8 busy last", {15'd0, status[12]}, 16'h1);
        idle("R8", 1);
        chk("R8 busy ended", {15'd0, status[12]}, 16'h0);

        // R10 global reset wipes state
        step("R10", 1'b1, mk(5'h00, 11'h0), 8'h0);
        idle("R10", NBUSY);
        step("R10", 1'b1, mk(5'h0F, 11'h1FF), 8'h0);
        chk("R10 wiped", status, 16'h0000);

        // random mix of commands and events
        for (int n = 0; n < 1500; n++) begin
            logic [4:0] ops [10] = '{5'h01, 5'h0D, 5'h0E, 5'h0F, 5'h0C, 5'h0B,
                                     5'h05, 5'h1F, 5'h03, 5'h00};
            int k = $urandom_range(0, 40);
            logic [7:0] e = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h0;
            if (k < 10 && !(k == 9 && $urandom_range(0, 3) != 0))
                step("R3 R6 R9 random", 1'b1, {ops[k], 11'($urandom)}, e);
            else
                step("R3 R6 R9 random", 1'b0, 16'h0, e);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule